// File: doc/BRIEF.md
# PHY Status Aggregation Register

This block builds the read-only status word that an Ethernet PHY management interface returns at register address 0x10. It gathers status from several internal sources. Some fields are live copies of level signals: the qualified signal detect, the descrambler lock and the pair-swap state. The other six fields are sticky latches. Each one is set by an event pulse from its source. It clears only when a different register that belongs to that source is read. A read of the status word itself never clears anything.

The management side supplies a read strobe and a 5-bit register address on every access. The block decodes the clearing addresses of all six latches from that pair. One configuration input picks how the signal-detect field is formed. The composed word is registered and always visible on `sts_word`. On a read of address 0x10, `rd_data` captures the word as it stood before that read's edge. A clearing read of another register therefore sees the pre-clear value there too.

Top module: `phy_status_agg`

## Requirements
- R1: A strobed read of address 0x10 loads `rd_data` with the value `sts_word` held in the cycle of the read. At all other times `rd_data` keeps its value.
- R2: Bits 15:9 of `sts_word` always read as 0.
- R3: Bit 0 (receive error) sets one edge after a receive error pulse and holds until a strobed read of address 0x15.
- R4: Bit 1 (false carrier) sets one edge after a false carrier pulse and holds until a strobed read of address 0x14.
- R5: Bit 2 (inverted polarity) sets one edge after a polarity-inverted pulse and holds until a strobed read of address 0x1A.
- R6: Bit 3 (page received) sets one edge after a page-received pulse and holds until a strobed read of address 0x06.
- R7: Bit 4 (remote fault) sets one edge after a partner remote-fault pulse and holds until a strobed read of address 0x01.
- R8: Bit 5 (interrupt pending) sets one edge after an interrupt pulse and holds until a strobed read of address 0x12.
- R9: Bit 6 shows raw signal detect ANDed with descrambler lock when `sd_qual_en` is 1, and raw signal detect alone when it is 0. Bit 7 shows descrambler lock. Both appear one edge after the inputs.
- R10: Bit 8 shows the pair-swap input one edge later: 1 means swapped and 0 means normal.
- R11: If a set pulse and the clearing read of the same latch fall in one cycle, the latch ends set.
- R12: Synchronous reset drives `sts_word` and `rd_data` to 0. Reads of 0x10, of another latch's clearing address, or of an unrelated address, and reads without the strobe, leave every latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_err_pulse | input | 1 | Receive error event |
| false_carr_pulse | input | 1 | False carrier event |
| pol_inv_pulse | input | 1 | Inverted polarity detected event |
| page_rcv_pulse | input | 1 | Link code word page received event |
| rem_fault_pulse | input | 1 | Remote fault reported by partner |
| irq_pulse | input | 1 | Internal interrupt raised |
| raw_sd | input | 1 | Raw signal detect from the medium side |
| descr_lock | input | 1 | Descrambler lock |
| sd_qual_en | input | 1 | Config: qualify signal detect with lock |
| pairs_swapped | input | 1 | Live pair-swap state |
| rd_stb | input | 1 | Register read strobe |
| rd_addr | input | 5 | Register address of the read |
| sts_word | output | 16 | Registered status word |
| rd_data | output | 16 | Status word captured on a read of 0x10 |

## Verification
Random pulses arrive on all six latch inputs at a low rate, so the latches build up and hold for many cycles. They are mixed with strobed reads spread over 0x10, every clearing address and unrelated addresses. This separates a latch that clears on its own address from one that clears on the wrong address, on any read, or on 0x10. Directed steps put a set pulse and its own clearing read in the same cycle, which shows whether set or clear has priority. Further steps sweep all four combinations of signal detect and lock under both configuration values. Strobe-less reads of clearing addresses and back-to-back 0x10 reads expose a missing strobe qualification and stale capture in `rd_data`.

// File: rtl/phy_sts_pkg.sv
package phy_sts_pkg;
  localparam int STS_W      = 16;
  localparam int ADDR_W     = 5;
  localparam int NUM_STICKY = 6;

  // field positions inside the status word
  localparam int BIT_RXERR  = 0;
  localparam int BIT_FCARR  = 1;
  localparam int BIT_POL    = 2;
  localparam int BIT_PAGE   = 3;
  localparam int BIT_RFAULT = 4;
  localparam int BIT_IRQ    = 5;
  localparam int BIT_SD     = 6;
  localparam int BIT_LOCK   = 7;
  localparam int BIT_MDIX   = 8;
  localparam int LIVE_TOP   = BIT_MDIX;

  typedef struct packed {
    logic sd;
    logic lock;
    logic mdix;
  } live_t;
endpackage

// File: rtl/sts_clr_decode.sv
module sts_clr_decode #(
  parameter int AW = 5,
  parameter int N  = 6,
  parameter logic [N*AW-1:0] CLR_ADDRS = '0
) (
  input  logic          rd_stb,
  input  logic [AW-1:0] rd_addr,
  output logic [N-1:0]  clr_vec
);
  // one comparator per latch, each against its own clearing address
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign clr_vec[i] = rd_stb && (rd_addr == CLR_ADDRS[i*AW +: AW]);
  end
endmodule

// File: rtl/sts_sticky_bank.sv
module sts_sticky_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] q,
  output logic [N-1:0] q_nxt
);
  for (genvar i = 0; i < N; i++) begin : g_lat
    // set has priority so an event coinciding with a clear is kept
    assign q_nxt[i] = set_vec[i] | (q[i] & ~clr_vec[i]);

    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= q_nxt[i];
    end
  end
endmodule

// File: rtl/sts_live_sense.sv
module sts_live_sense
  import phy_sts_pkg::*;
(
  input  logic  raw_sd,
  input  logic  descr_lock,
  input  logic  sd_qual_en,
  input  logic  pairs_swapped,
  output live_t live
);
  always_comb begin
    live.sd   = raw_sd & (sd_qual_en ? descr_lock : 1'b1);
    live.lock = descr_lock;
    live.mdix = pairs_swapped;
  end
endmodule

// File: rtl/phy_status_agg.sv
module phy_status_agg
  import phy_sts_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int W  = STS_W,
  parameter logic [AW-1:0] STS_ADDR    = 5'h10,
  parameter logic [AW-1:0] RXERR_ADDR  = 5'h15,
  parameter logic [AW-1:0] FCARR_ADDR  = 5'h14,
  parameter logic [AW-1:0] POL_ADDR    = 5'h1A,
  parameter logic [AW-1:0] PAGE_ADDR   = 5'h06,
  parameter logic [AW-1:0] RFAULT_ADDR = 5'h01,
  parameter logic [AW-1:0] IRQ_ADDR    = 5'h12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_err_pulse,
  input  logic          false_carr_pulse,
  input  logic          pol_inv_pulse,
  input  logic          page_rcv_pulse,
  input  logic          rem_fault_pulse,
  input  logic          irq_pulse,
  input  logic          raw_sd,
  input  logic          descr_lock,
  input  logic          sd_qual_en,
  input  logic          pairs_swapped,
  input  logic          rd_stb,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  sts_word,
  output logic [W-1:0]  rd_data
);
  localparam int N = NUM_STICKY;
  // packed in latch index order: index i sits at bits [i*AW +: AW]
  localparam logic [N*AW-1:0] CLR_ADDRS =
    {IRQ_ADDR, RFAULT_ADDR, PAGE_ADDR, POL_ADDR, FCARR_ADDR, RXERR_ADDR};

  logic [N-1:0] set_vec, clr_vec, lat_q, lat_nxt;
  live_t        live;
  logic [W-1:0] word_nxt;

  assign set_vec[BIT_RXERR]  = rx_err_pulse;
  assign set_vec[BIT_FCARR]  = false_carr_pulse;
  assign set_vec[BIT_POL]    = pol_inv_pulse;
  assign set_vec[BIT_PAGE]   = page_rcv_pulse;
  assign set_vec[BIT_RFAULT] = rem_fault_pulse;
  assign set_vec[BIT_IRQ]    = irq_pulse;

  sts_clr_decode #(.AW(AW), .N(N), .CLR_ADDRS(CLR_ADDRS)) u_dec (
    .rd_stb  (rd_stb),
    .rd_addr (rd_addr),
    .clr_vec (clr_vec)
  );

  sts_sticky_bank #(.N(N)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .q       (lat_q),
    .q_nxt   (lat_nxt)
  );

  sts_live_sense u_live (
    .raw_sd        (raw_sd),
    .descr_lock    (descr_lock),
    .sd_qual_en    (sd_qual_en),
    .pairs_swapped (pairs_swapped),
    .live          (live)
  );

  always_comb begin
    word_nxt           = '0;
    word_nxt[N-1:0]    = lat_nxt;
    word_nxt[BIT_SD]   = live.sd;
    word_nxt[BIT_LOCK] = live.lock;
    word_nxt[BIT_MDIX] = live.mdix;
  end

  wire sts_read = rd_stb && (rd_addr == STS_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_word <= '0;
      rd_data  <= '0;
    end else begin
      sts_word <= word_nxt;
      if (sts_read) rd_data <= sts_word;
    end
  end
endmodule

// File: rtl/phy_status_agg_chk.sv
module phy_status_agg_chk (
  input logic        clk,
  input logic        rst,
  input logic        rx_err_pulse,
  input logic        irq_pulse,
  input logic        rem_fault_pulse,
  input logic        raw_sd,
  input logic        descr_lock,
  input logic        sd_qual_en,
  input logic        pairs_swapped,
  input logic        rd_stb,
  input logic [4:0]  rd_addr,
  input logic [15:0] sts_word,
  input logic [15:0] rd_data
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    sts_word[15:9] == 7'd0);

  assert_capture_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && rd_addr == 5'h10) |=> rd_data == $past(sts_word));

  assert_rxerr_set_R3: assert property (@(posedge clk) disable iff (rst)
    rx_err_pulse |=> sts_word[0]);

  assert_rxerr_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (sts_word[0] && !(rd_stb && rd_addr == 5'h15)) |=> sts_word[0]);

  assert_rfault_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && rd_addr == 5'h01 && !rem_fault_pulse) |=> !sts_word[4]);

  assert_irq_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (irq_pulse && rd_stb && rd_addr == 5'h12) |=> sts_word[5]);

  assert_sd_gate_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sts_word[6] == $past(raw_sd && (!sd_qual_en || descr_lock)));

  assert_mdix_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sts_word[8] == $past(pairs_swapped));

  assert_reset_R12: assert property (@(posedge clk)
    rst |=> (sts_word == 16'd0 && rd_data == 16'd0));
endmodule

bind phy_status_agg phy_status_agg_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .rx_err_pulse    (rx_err_pulse),
  .irq_pulse       (irq_pulse),
  .rem_fault_pulse (rem_fault_pulse),
  .raw_sd          (raw_sd),
  .descr_lock      (descr_lock),
  .sd_qual_en      (sd_qual_en),
  .pairs_swapped   (pairs_swapped),
  .rd_stb          (rd_stb),
  .rd_addr         (rd_addr),
  .sts_word        (sts_word),
  .rd_data         (rd_data)
);

// File: tb/phy_status_agg_bench.sv
module phy_status_agg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] ev = '0;
  logic raw_sd = 0, descr_lock = 0, sd_qual_en = 0, pairs_swapped = 0;
  logic rd_stb = 0;
  logic [4:0] rd_addr = '0;
  logic [15:0] sts_word, rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  logic [5:0]  m_lat = '0;
  logic [15:0] m_sts = '0;
  logic [15:0] m_rd  = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_status_agg u_phy_status_agg (
    .clk (clk), .rst (rst),
    .rx_err_pulse (ev[0]), .false_carr_pulse (ev[1]), .pol_inv_pulse (ev[2]),
    .page_rcv_pulse (ev[3]), .rem_fault_pulse (ev[4]), .irq_pulse (ev[5]),
    .raw_sd (raw_sd), .descr_lock (descr_lock), .sd_qual_en (sd_qual_en),
    .pairs_swapped (pairs_swapped), .rd_stb (rd_stb), .rd_addr (rd_addr),
    .sts_word (sts_word), .rd_data (rd_data)
  );

  function automatic logic [4:0] clr_addr(input int i);
    case (i)
      0: return 5'h15;
      1: return 5'h14;
      2: return 5'h1A;
      3: return 5'h06;
      4: return 5'h01;
      default: return 5'h12;
    endcase
  endfunction

  function automatic string lat_req(input int i);
    case (i)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input string ctx,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, ctx, act, exp);
    end
  endtask

  // drive one cycle, advance the model, check all fields after the edge
  task automatic step(input string ctx, input logic [5:0] e, input logic rs,
                      input logic lk, input logic cfg, input logic mx,
                      input logic rd, input logic [4:0] a);
    logic [5:0]  lat_n;
    logic [15:0] sts_n;
    ev = e; raw_sd = rs; descr_lock = lk; sd_qual_en = cfg;
    pairs_swapped = mx; rd_stb = rd; rd_addr = a;
    for (int i = 0; i < 6; i++)
      lat_n[i] = e[i] | (m_lat[i] & ~(rd && a == clr_addr(i)));
    sts_n = {7'd0, mx, lk, rs & (cfg ? lk : 1'b1), lat_n};
    if (rd && a == 5'h10) m_rd = m_sts;
    m_lat = lat_n;
    m_sts = sts_n;
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 6; i++)
      check(lat_req(i), ctx, 16'(sts_word[i]), 16'(m_sts[i]));
    check("R9", ctx, 16'(sts_word[7:6]), 16'(m_sts[7:6]));
    check("R10", ctx, 16'(sts_word[8]), 16'(m_sts[8]));
    check("R2", ctx, 16'(sts_word[15:9]), 16'd0);
    check("R1", ctx, rd_data, m_rd);
  endtask

  initial begin
    int unsigned r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R12", "reset word", sts_word, 16'd0);
    check("R12", "reset rd_data", rd_data, 16'd0);
    rst = 1'b0;

    // directed: each latch set, survives 0x10 and unrelated reads, then cleared
    for (int i = 0; i < 6; i++) begin
      step("set", 6'(1 << i), 0, 0, 0, 0, 0, 5'h00);
      step("R12 read sts", '0, 0, 0, 0, 0, 1, 5'h10);
      step("R12 read unrelated", '0, 0, 0, 0, 0, 1, 5'h1F);
      step("R12 read other clr", '0, 0, 0, 0, 0, 1, clr_addr((i + 1) % 6));
      step("R12 no strobe", '0, 0, 0, 0, 0, 0, clr_addr(i));
      step("own clear", '0, 0, 0, 0, 0, 1, clr_addr(i));
    end
    // R11: set and own clear in one cycle
    step("prime", 6'h3F, 0, 0, 0, 0, 0, 5'h00);
    for (int i = 0; i < 6; i++)
      step("R11 set+clr", 6'(1 << i), 0, 0, 0, 0, 1, clr_addr(i));
    // R1: capture before clear, back-to-back status reads
    step("R1 set all", 6'h3F, 1, 1, 1, 1, 0, 5'h00);
    step("R1 read", '0, 1, 1, 1, 1, 1, 5'h10);
    step("R1 read again", '0, 0, 0, 0, 0, 1, 5'h10);
    step("R1 no read", '0, 1, 0, 0, 1, 0, 5'h10);
    // R9 / R10: all signal-detect combinations under both configs
    for (int c = 0; c < 8; c++)
      step("R9 sd sweep", '0, c[0], c[1], c[2], c[0] ^ c[1], 0, 5'h00);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] e;
      logic [4:0] a;
      for (int i = 0; i < 6; i++) e[i] = ($urandom % 16) == 0;
      r = $urandom % 10;
      if (r < 3) a = 5'h10;
      else if (r < 8) a = clr_addr(int'($urandom % 6));
      else a = 5'($urandom);
      step("random", e, 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), ($urandom % 3) == 0, a);
    end

    // R12: reset mid-run
    step("load", 6'h3F, 1, 1, 0, 1, 1, 5'h10);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R12", "reset word mid", sts_word, 16'd0);
    check("R12", "reset rd_data mid", rd_data, 16'd0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule